// File: doc/BRIEF.md
# Stereo Sample Gain and Routing Stage

This block sits in the sample-rate part of an audio output path. It takes one stereo pair of 24-bit two's-complement samples per sample period, marked by a one-cycle strobe. It scales each channel by an 8-bit linear gain code and routes the scaled pair to two outputs. Each output can carry left, right, the average of both, or silence. Register fields supply the inputs: two gain codes, a load enable, a shared-code select, a soft-mute request, a 4-bit route mode, a converter-off bit and a zero-detect mute request. The result appears one clock after the strobe and holds until the next strobe.

Gain codes take effect only on a strobe where load is set. A new code applies from the sample after it is loaded. Soft mute lowers the active gain of each channel by one code per sample until it reaches zero. Releasing soft mute raises the gain again by one code per sample until it reaches the loaded code. The converter-off bit and the zero-detect request each blank both outputs at once. The gain ramp keeps running underneath while the outputs are blanked.

Top module: `stereo_gain_stage`

## Requirements
- R1: After reset both active gains and both loaded codes are 0xFF, `out_valid` is 0 and both outputs are 0.
- R2: A sample is scaled by its channel's active code c. Code 0xFF passes the sample unchanged. Any other code gives floor(x*c/256), computed as an arithmetic right shift by 8, so code 0x00 gives 0.
- R3: Codes are captured only on a strobe with `att_load` = 1. Otherwise the loaded codes hold and changes on the code inputs have no effect. When soft mute is not active, the active gain takes the loaded code, so a code loaded on strobe k scales sample k+1 onward.
- R4: With `att_common` = 1 at load, the right channel loads the left code. With it clear, each channel loads its own code.
- R5: While `soft_mute` = 1, each strobe lowers each active gain by 1 until it reaches 0, where it stays. From active code C, exactly C samples have a nonzero output before silence.
- R6: After `soft_mute` drops, each strobe raises the active gain by 1 until it reaches the loaded code. A code loaded at or below the current gain during the ramp is taken at once.
- R7: `route_mode[1:0]` selects the left output and `route_mode[3:2]` selects the right output: 00 = zero, 01 = scaled left, 10 = scaled right, 11 = average. 1001 is normal stereo.
- R8: The average is (L+R) formed with one extra bit, then arithmetically shifted right by 1, so it never overflows.
- R9: When `dac_off` or `zero_mute` is 1 on a strobe, both outputs of that sample are 0.
- R10: `out_valid` pulses one cycle after each strobe. The outputs change only one cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe per sample period |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| att_code_l | input | 8 | Left gain code |
| att_code_r | input | 8 | Right gain code |
| att_load | input | 1 | Capture gain codes on this strobe |
| att_common | input | 1 | Right channel loads the left code |
| soft_mute | input | 1 | Ramp gains down to zero |
| route_mode | input | 4 | Output source select, two bits per output |
| dac_off | input | 1 | Blank both outputs |
| zero_mute | input | 1 | Zero-detect mute request, blanks both outputs |
| out_valid | output | 1 | Result strobe |
| out_left | output | 24 | Left output sample |
| out_right | output | 24 | Right output sample |

## Verification
Two cases can fall on the same strobe. In the first, a load lands while the soft-mute ramp is running. The bench loads a new pair of codes in the middle of a mute ramp, which must keep decrementing. It then loads a lower code in the middle of the release ramp, which must be taken at once. In the second, a forced blank coincides with the ramp. Blank samples are sent during the mute ramp, and the samples after the blank must show that the ramp kept stepping underneath. A scoreboard model built from the requirements judges each case sample by sample. Explicit counts of the nonzero samples check the length of each ramp.

// File: rtl/sgs_pkg.sv
// Shared types for the stereo gain stage.
package sgs_pkg;
    // Source selection for one output lane.
    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_LEFT  = 2'b01,
        SRC_RIGHT = 2'b10,
        SRC_AVG   = 2'b11
    } src_sel_e;
endpackage

// File: rtl/sgs_level_ctrl.sv
// Per-channel gain level controller.
// Holds the loaded gain code and the active gain applied to samples.
// The active gain decrements under soft mute and ramps back after release.
// Assumes step is a one-cycle strobe per sample period.
module sgs_level_ctrl #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load_en,
    input  logic [CODE_W-1:0] code_new,
    input  logic              mute_req,
    output logic [CODE_W-1:0] level,
    output logic [CODE_W-1:0] target
);
    localparam logic [CODE_W-1:0] UNITY = '1;
    localparam logic [CODE_W-1:0] ONE   = CODE_W'(1);

    logic [CODE_W-1:0] tgt_q;
    logic [CODE_W-1:0] lvl_q;
    logic              rec_q;
    logic [CODE_W-1:0] tgt_next;

    // Loaded code as seen by this strobe's level update.
    always_comb tgt_next = load_en ? code_new : tgt_q;

    // Update loaded code, active level and recovery flag once per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= UNITY;
            lvl_q <= UNITY;
            rec_q <= 1'b0;
        end else if (step) begin
            tgt_q <= tgt_next;
            if (mute_req) begin
                rec_q <= 1'b1;
                if (lvl_q != '0) lvl_q <= lvl_q - ONE;
            end else if (rec_q && (lvl_q < tgt_next)) begin
                lvl_q <= lvl_q + ONE;
            end else begin
                lvl_q <= tgt_next;
                rec_q <= 1'b0;
            end
        end
    end

    assign level  = lvl_q;
    assign target = tgt_q;
endmodule

// File: rtl/sgs_scaler.sv
// Linear gain multiply for one channel.
// Output = floor(din * code / 2^CODE_W), with the all-ones code passing din exactly.
// Purely combinational; assumes a two's-complement input.
module sgs_scaler #(
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 8
) (
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic        [CODE_W-1:0]   code,
    output logic signed [SAMPLE_W-1:0] dout
);
    localparam int PROD_W = SAMPLE_W + CODE_W + 1;

    logic signed [CODE_W:0]   gain_s;
    logic signed [PROD_W-1:0] prod;

    // Form the signed product with a zero-extended gain.
    always_comb begin
        gain_s = $signed({1'b0, code});
        prod   = PROD_W'(din) * PROD_W'(gain_s);
    end

    // Shift down by the code width, or pass through at unity.
    always_comb dout = (code == '1) ? din : prod[CODE_W +: SAMPLE_W];
endmodule

// File: rtl/sgs_router.sv
// Output routing for the scaled stereo pair.
// Each lane picks zero, left, right or the average, using two bits of the mode.
// A force input blanks both lanes. Combinational.
module sgs_router #(
    parameter int SAMPLE_W = 24
) (
    input  logic signed [SAMPLE_W-1:0] gain_l,
    input  logic signed [SAMPLE_W-1:0] gain_r,
    input  logic        [3:0]          mode,
    input  logic                       force_zero,
    output logic signed [SAMPLE_W-1:0] lane_l,
    output logic signed [SAMPLE_W-1:0] lane_r
);
    import sgs_pkg::*;

    localparam int SUM_W = SAMPLE_W + 1;
    localparam int LANES = 2;

    logic signed [SUM_W-1:0]    sum;
    logic signed [SAMPLE_W-1:0] avg;
    logic signed [SAMPLE_W-1:0] lane [LANES];

    // Average with one guard bit and an arithmetic halving.
    always_comb begin
        sum = SUM_W'(gain_l) + SUM_W'(gain_r);
        avg = sum[SUM_W-1:1];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        src_sel_e sel;
        assign sel = src_sel_e'(mode[2*i +: 2]);
        // Select this lane's source.
        always_comb begin
            if (force_zero) lane[i] = '0;
            else begin
                case (sel)
                    SRC_LEFT:  lane[i] = gain_l;
                    SRC_RIGHT: lane[i] = gain_r;
                    SRC_AVG:   lane[i] = avg;
                    default:   lane[i] = '0;
                endcase
            end
        end
    end

    assign lane_l = lane[0];
    assign lane_r = lane[1];
endmodule

// File: rtl/stereo_gain_stage.sv
// Stereo gain, soft-mute and routing stage.
// Scales each sample by the channel's active gain, routes the pair and registers the result.
// The output appears one cycle after in_valid and holds until the next strobe.
module stereo_gain_stage #(
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic        [CODE_W-1:0]   att_code_l,
    input  logic        [CODE_W-1:0]   att_code_r,
    input  logic                       att_load,
    input  logic                       att_common,
    input  logic                       soft_mute,
    input  logic        [3:0]          route_mode,
    input  logic                       dac_off,
    input  logic                       zero_mute,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);
    logic [CODE_W-1:0]          code_r_src;
    logic [CODE_W-1:0]          level_l, level_r, target_l, target_r;
    logic signed [SAMPLE_W-1:0] scaled_l, scaled_r, route_l, route_r;
    logic                       blank;

    // Right channel code source: own code or the shared left code.
    always_comb code_r_src = att_common ? att_code_l : att_code_r;
    // Either blanking request zeroes both outputs.
    always_comb blank = dac_off | zero_mute;

    sgs_level_ctrl #(.CODE_W(CODE_W)) u_lvl_l (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .load_en(att_load),
        .code_new(att_code_l), .mute_req(soft_mute),
        .level(level_l), .target(target_l)
    );

    sgs_level_ctrl #(.CODE_W(CODE_W)) u_lvl_r (
        .clk(clk), .rst_n(rst_n), .step(in_valid), .load_en(att_load),
        .code_new(code_r_src), .mute_req(soft_mute),
        .level(level_r), .target(target_r)
    );

    sgs_scaler #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_scl_l (
        .din(in_left), .code(level_l), .dout(scaled_l)
    );

    sgs_scaler #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_scl_r (
        .din(in_right), .code(level_r), .dout(scaled_r)
    );

    sgs_router #(.SAMPLE_W(SAMPLE_W)) u_route (
        .gain_l(scaled_l), .gain_r(scaled_r), .mode(route_mode),
        .force_zero(blank), .lane_l(route_l), .lane_r(route_r)
    );

    // Register the routed pair on each strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_left  <= route_l;
                out_right <= route_r;
            end
        end
    end
endmodule

// File: rtl/sgs_checker.sv
// Temporal checks for stereo_gain_stage, attached with bind.
module sgs_checker #(
    parameter int SAMPLE_W = 24,
    parameter int CODE_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                att_load,
    input logic                att_common,
    input logic                soft_mute,
    input logic                dac_off,
    input logic                zero_mute,
    input logic [CODE_W-1:0]   att_code_l,
    input logic [CODE_W-1:0]   lvl_l,
    input logic [CODE_W-1:0]   tgt_l,
    input logic [CODE_W-1:0]   tgt_r,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right));
    // R9
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (dac_off || zero_mute) |=> out_left == '0 && out_right == '0);
    // R3
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid || !att_load) |=> $stable(tgt_l) && $stable(tgt_r));
    // R4
    common_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && att_load && att_common |=> tgt_r == $past(att_code_l));
    // R5
    mute_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && soft_mute && lvl_l != '0 |=> lvl_l == $past(lvl_l) - CODE_W'(1));
    // R5
    mute_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && soft_mute && lvl_l == '0 |=> lvl_l == '0);
    // R6
    release_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !soft_mute |=> lvl_l <= tgt_l);
endmodule

bind stereo_gain_stage sgs_checker #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_sgs_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .att_load(att_load),
    .att_common(att_common), .soft_mute(soft_mute), .dac_off(dac_off),
    .zero_mute(zero_mute), .att_code_l(att_code_l), .lvl_l(level_l),
    .tgt_l(target_l), .tgt_r(target_r), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
);

// File: tb/stereo_gain_stage_bench.sv
`timescale 1ns/1ps
module stereo_gain_stage_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [23:0] in_left = '0, in_right = '0;
    logic [7:0] att_code_l = 8'hFF, att_code_r = 8'hFF;
    logic att_load = 1'b0, att_common = 1'b0, soft_mute = 1'b0;
    logic [3:0] route_mode = 4'b1001;
    logic dac_off = 1'b0, zero_mute = 1'b0;
    logic out_valid;
    logic signed [23:0] out_left, out_right;

    always #2 clk = ~clk;

    stereo_gain_stage u_stereo_gain_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .att_code_l(att_code_l), .att_code_r(att_code_r),
        .att_load(att_load), .att_common(att_common), .soft_mute(soft_mute),
        .route_mode(route_mode), .dac_off(dac_off), .zero_mute(zero_mute),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    typedef struct {
        logic signed [23:0] l;
        logic signed [23:0] r;
        string tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Reference model state built from the requirements.
    int m_tl = 255, m_tr = 255, m_al = 255, m_ar = 255;
    bit m_rl = 0, m_rr = 0;

    function automatic logic signed [23:0] f_gain(logic signed [23:0] x, int c);
        longint p;
        if (c == 255) return x;
        p = longint'(x) * c;
        return 24'(p >>> 8);
    endfunction

    function automatic logic signed [23:0] f_pick(logic [1:0] s, logic signed [23:0] a,
                                                  logic signed [23:0] b);
        longint sm;
        sm = longint'(a) + longint'(b);
        case (s)
            2'b01: return a;
            2'b10: return b;
            2'b11: return 24'(sm >>> 1);
            default: return '0;
        endcase
    endfunction

    task automatic lvl_upd(inout int a, inout bit rec, input int t);
        if (soft_mute) begin
            rec = 1;
            if (a > 0) a = a - 1;
        end else if (rec && a < t) a = a + 1;
        else begin a = t; rec = 0; end
    endtask

    // Driver: strobe one pair, push the expected result, advance the model.
    task automatic send(input logic signed [23:0] l, input logic signed [23:0] r,
                        input string tag);
        exp_t e;
        logic signed [23:0] gl, gr;
        @(negedge clk);
        in_left = l; in_right = r; in_valid = 1'b1;
        gl = f_gain(l, m_al);
        gr = f_gain(r, m_ar);
        if (dac_off || zero_mute) begin e.l = '0; e.r = '0; end
        else begin
            e.l = f_pick(route_mode[1:0], gl, gr);
            e.r = f_pick(route_mode[3:2], gl, gr);
        end
        e.tag = tag;
        sb.push_back(e);
        if (att_load) begin
            m_tl = int'(att_code_l);
            m_tr = att_common ? int'(att_code_l) : int'(att_code_r);
        end
        lvl_upd(m_al, m_rl, m_tl);
        lvl_upd(m_ar, m_rr, m_tr);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pop and compare each produced result.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected output l=%0d r=%0d expected none", out_left, out_right);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (out_left !== e.l || out_right !== e.r) begin
                    bad++;
                    $display("FAIL %s actual l=%0d r=%0d expected l=%0d r=%0d",
                             e.tag, out_left, out_right, e.l, e.r);
                end
            end
        end
    end

    task automatic check(input bit ok, input string msg, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, expv);
        end
    endtask

    task automatic summary();
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R10 missing outputs actual=0 expected=%0d", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0 && out_left == 0 && out_right == 0, "R1 reset outputs",
              int'(out_left), 0);
        @(negedge clk) rst_n = 1'b1;

        // R1 unity defaults, R7 stereo, R10 pairing
        send(24'sh123456, -24'sh000777, "R1 default unity");
        send(24'sh7FFFFF, -24'sh800000, "R1 full scale");

        // R3 load disabled: code changes ignored
        att_code_l = 8'h40; att_code_r = 8'h80;
        send(24'sh100000, 24'sh100000, "R3 codes ignored without load");
        att_load = 1'b1;
        send(24'sh100000, 24'sh100000, "R3 load applies next sample");
        att_load = 1'b0;
        att_code_l = 8'h01; att_code_r = 8'h02;
        send(24'sh100000, -24'sh100000, "R2 R3 loaded gains");

        // R4 common code
        att_common = 1'b1; att_load = 1'b1; att_code_l = 8'h10; att_code_r = 8'hF0;
        send(24'sh0ABCDE, 24'sh0ABCDE, "R4 common load");
        att_load = 1'b0;
        send(24'sh0ABCDE, -24'sh0ABCDE, "R4 common shared code");
        att_common = 1'b0;

        // R2 scaling across codes
        foreach (sb[i]) ;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] c;
            case (k)
                0: c = 8'h00; 1: c = 8'h01; 2: c = 8'h7F;
                3: c = 8'h80; 4: c = 8'hFE; default: c = 8'hFF;
            endcase
            att_load = 1'b1; att_code_l = c; att_code_r = ~c;
            send(-24'sh012345, 24'sh3FFFFF, "R2 load code");
            att_load = 1'b0;
            send(-24'sh012345, 24'sh3FFFFF, "R2 scaled by code");
        end

        // R7 R8 every route mode
        att_load = 1'b1; att_code_l = 8'hFF; att_code_r = 8'hFF;
        send(0, 0, "R7 restore unity");
        att_load = 1'b0;
        for (int m = 0; m < 16; m++) begin
            route_mode = 4'(m);
            send(24'sh123456, -24'sh0F0001, "R7 route mode");
        end
        route_mode = 4'b1111;
        send(24'sh7FFFFF, 24'sh7FFFFF, "R8 average guard positive");
        send(-24'sh800000, -24'sh800000, "R8 average guard negative");
        send(24'sh000001, -24'sh000004, "R8 average rounds down");
        route_mode = 4'b1001;

        // R9 blanking
        dac_off = 1'b1;
        send(24'sh111111, 24'sh222222, "R9 dac off");
        dac_off = 1'b0; zero_mute = 1'b1;
        send(24'sh111111, 24'sh222222, "R9 zero mute");
        zero_mute = 1'b0;

        // R5 ramp length from code 20
        att_load = 1'b1; att_code_l = 8'd20; att_code_r = 8'd20;
        send(24'sh100000, 24'sh100000, "R5 load 20");
        att_load = 1'b0;
        soft_mute = 1'b1;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            send(24'sh100000, 24'sh100000, "R5 mute ramp");
            if (out_left != 0) n++;
        end
        check(n == 20, "R5 ramp length", n, 20);

        // R6 release ramp back to 20
        soft_mute = 1'b0;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            send(24'sh100000, 24'sh100000, "R6 release ramp");
            if (out_left != f_gain(24'sh100000, 20)) n++;
        end
        check(n == 20, "R6 ramp up length", n, 20);

        // Coincident: load during mute ramp, blank during ramp
        att_load = 1'b1; att_code_l = 8'd12; att_code_r = 8'd30;
        send(24'sh200000, 24'sh200000, "R3 load 12/30");
        att_load = 1'b0;
        soft_mute = 1'b1;
        send(24'sh200000, 24'sh200000, "R5 ramp start");
        att_load = 1'b1; att_code_l = 8'd200; att_code_r = 8'd100;
        send(24'sh200000, 24'sh200000, "R5 load during mute");
        att_load = 1'b0;
        dac_off = 1'b1;
        send(24'sh200000, 24'sh200000, "R9 blank during ramp");
        dac_off = 1'b0;
        for (int i = 0; i < 4; i++) send(24'sh200000, 24'sh200000, "R5 ramp after blank");
        soft_mute = 1'b0;
        for (int i = 0; i < 3; i++) send(24'sh200000, 24'sh200000, "R6 release start");
        att_load = 1'b1; att_code_l = 8'd2; att_code_r = 8'd2;
        send(24'sh200000, 24'sh200000, "R6 lower load during release");
        att_load = 1'b0;
        send(24'sh200000, 24'sh200000, "R6 lowered code taken");
        check(out_left == f_gain(24'sh200000, 2), "R6 lowered code level",
              int'(out_left), int'(f_gain(24'sh200000, 2)));

        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
    end
endmodule